// File: doc/BRIEF.md
# Synchronous Burst SRAM with Lane Writes

A single-port synchronous static memory of 36-bit words, sized by a parameter, meant to sit behind a processor as a secondary cache data store. Every address, data and control input is taken in at the rising clock edge. The only exceptions are the output enable, which acts at once, and the burst-order select. The order select is read in each clock cycle and should be held steady.

A burst opens on either of two start strobes. The processor-side strobe opens a read burst. The controller-side strobe opens a read or a write burst, depending on the write controls. A 2-bit counter then steps the low two address bits each time the advance input is low. It steps them in either linear or interleaved order, and the upper bits stay fixed. Writes complete at the clock edge and can touch any combination of the four 9-bit lanes. Read data is registered and appears after the edge that samples the read cycle. The chip-side pad uses the enable output to drive or release the data bus.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset no burst is active and `rd_en` stays low until a burst is started.
- R2: A cycle with either strobe low and `ce_n` low starts a burst. It takes `addr` as the first address and clears the burst counter.
- R3: In cycles with no strobe, the counter steps by one only when `adv_n` is low. With `adv_n` high, the same address is accessed again.
- R4: With `order_lin` high, the low two address bits are (start + count) mod 4, and the upper bits are unchanged.
- R5: With `order_lin` low, the low two address bits are start XOR count, and the upper bits are unchanged.
- R6: With `we_n` low, each lane i whose `lane_we_n[i]` is low is written. Lane i is bits [9i+8:9i] of `wr_data`, so lane 0 is [8:0] and lane 3 is [35:27]. Lanes whose bit is high keep their contents.
- R7: `all_we_n` low writes all four lanes, whatever the values of `lane_we_n` and `we_n`.
- R8: A cycle with `strb_cpu_n` low is always a read and ignores the write controls. When both strobes are low, the processor-side strobe decides.
- R9: A read cycle sampled at edge E puts the word on `rd_data` and raises `rd_en` after E. Both hold until the next edge.
- R10: A strobe with `ce_n` high ends the burst and drops `rd_en` after that edge. Later cycles with no strobe access nothing.
- R11: `oe_n` high forces `rd_en` low without waiting for a clock edge, and it leaves the burst state unchanged.
- R12: After a write cycle, `rd_en` is low for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, sampled on strobe cycles, active low |
| strb_cpu_n | input | 1 | Processor-side burst start, read only, active low |
| strb_ctl_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr | input | ADDR_W | Word address |
| wr_data | input | 36 | Write data, four 9-bit lanes |
| lane_we_n | input | 4 | Per-lane write select, active low |
| all_we_n | input | 1 | Write all lanes, active low |
| we_n | input | 1 | Write enable qualifying lane selects, active low |
| oe_n | input | 1 | Output enable, immediate, active low |
| rd_data | output | 36 | Registered read word |
| rd_en | output | 1 | High while the pad must drive `rd_data`; low means high impedance |

## Verification
The hardest case to reach is a mid-burst address in interleaved order from a non-zero start, held by a pause in advance. Reaching it needs a strobe, several advance pulses and the right order select in the right sequence. The bench sweeps every start offset in both orders over every upper address. Each read burst includes a hold cycle. Every beat is compared against a bench-side reference array that is filled by write bursts with random lane masks. The deselect, both-strobe and immediate output-enable cases are then driven directly.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic [LANES-1:0]  mask;
    } acc_t;

    // low address bits for a beat of the burst
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input logic              lin
    );
        return lin ? BEAT_W'(start + cnt) : (start ^ cnt);
    endfunction

    // lane write mask from the three write controls (all active low)
    function automatic logic [LANES-1:0] write_lanes(
        input logic             all_n,
        input logic             wen_n,
        input logic [LANES-1:0] lane_n
    );
        if (!all_n)
            return '1;
        else if (!wen_n)
            return ~lane_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ce_n,
    input  logic                      strb_cpu_n,
    input  logic                      strb_ctl_n,
    input  logic                      adv_n,
    input  logic                      order_lin,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic                      all_we_n,
    input  logic                      we_n,
    output acc_t                      acc,
    output logic [ADDR_W-1:0]         acc_addr
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic                   active_q, active_d;
    logic [ADDR_W-1:0]      base_q, base_d;
    logic [BEAT_W-1:0]      cnt_q, cnt_d;
    logic                   start;
    logic [LANES-1:0]       wmask;

    always_comb begin
        start    = !strb_cpu_n || !strb_ctl_n;
        wmask    = write_lanes(all_we_n, we_n, lane_we_n);
        active_d = active_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        acc.kind = ACC_NONE;
        acc.mask = '0;
        if (start) begin
            if (ce_n) begin
                active_d = 1'b0;
            end else begin
                active_d = 1'b1;
                base_d   = addr;
                cnt_d    = '0;
                if (!strb_cpu_n || wmask == '0) begin
                    acc.kind = ACC_READ;
                end else begin
                    acc.kind = ACC_WRITE;
                    acc.mask = wmask;
                end
            end
        end else if (active_q) begin
            if (!adv_n)
                cnt_d = cnt_q + 1'b1;
            if (wmask == '0) begin
                acc.kind = ACC_READ;
            end else begin
                acc.kind = ACC_WRITE;
                acc.mask = wmask;
            end
        end
        acc_addr = {base_d[ADDR_W-1 -: UP_W], beat_lo(base_d[BEAT_W-1:0], cnt_d, order_lin)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            cnt_q    <= cnt_d;
        end
    end

    // R3
    adv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && active_q && adv_n) |=> (cnt_q == $past(cnt_q)));

    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !ce_n) |=> (cnt_q == '0 && base_q == $past(addr) && active_q));

    // R10
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (start && ce_n) |=> !active_q);

    // R8
    cpu_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && !ce_n) |-> (acc.kind == ACC_READ && acc.mask == '0));

endmodule

// File: rtl/burst_sram_mem.sv
module burst_sram_mem
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  acc_t               acc,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] rd_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (acc.kind == ACC_WRITE && acc.mask[g])
                lane_mem[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
            if (acc.kind == ACC_READ)
                rd_lane[g] <= lane_mem[acc_addr];
        end

        assign rd_word[g*LANE_W +: LANE_W] = rd_lane[g];
    end

endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out
    import burst_sram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    input  logic oe_n,
    output logic rd_en
);

    logic drive_q;

    always_ff @(posedge clk) begin
        if (rst)
            drive_q <= 1'b0;
        else
            drive_q <= (acc.kind == ACC_READ);
    end

    assign rd_en = drive_q && !oe_n;

    // R12
    wr_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == ACC_WRITE) |=> !rd_en);

    // R10
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.kind == ACC_NONE) |=> !rd_en);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce_n,
    input  logic                     strb_cpu_n,
    input  logic                     strb_ctl_n,
    input  logic                     adv_n,
    input  logic                     order_lin,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [35:0]              wr_data,
    input  logic [3:0]               lane_we_n,
    input  logic                     all_we_n,
    input  logic                     we_n,
    input  logic                     oe_n,
    output logic [35:0]              rd_data,
    output logic                     rd_en
);

    acc_t               acc;
    logic [ADDR_W-1:0]  acc_addr;

    burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .order_lin  (order_lin),
        .addr       (addr),
        .lane_we_n  (lane_we_n),
        .all_we_n   (all_we_n),
        .we_n       (we_n),
        .acc        (acc),
        .acc_addr   (acc_addr)
    );

    burst_sram_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .acc      (acc),
        .acc_addr (acc_addr),
        .wr_data  (wr_data),
        .rd_word  (rd_data)
    );

    burst_sram_out u_out (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .oe_n  (oe_n),
        .rd_en (rd_en)
    );

    // R11
    always_comb begin
        if (!rst && oe_n)
            oe_off_chk: assert (!rd_en);
    end

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b0, strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
    logic          order_lin = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wr_data = '0;
    logic [3:0]    lane_we_n = 4'hF;
    logic          all_we_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [35:0]   rd_data;
    logic          rd_en;

    int checks = 0;
    int fails  = 0;

    logic [35:0] ref_mem [DEPTH];
    bit          m_act = 0;
    int          m_base = 0;
    int          m_k = 0;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) u_burst_sram (
        .clk(clk), .rst(rst), .ce_n(ce_n), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .order_lin(order_lin),
        .addr(addr), .wr_data(wr_data), .lane_we_n(lane_we_n),
        .all_we_n(all_we_n), .we_n(we_n), .oe_n(oe_n),
        .rd_data(rd_data), .rd_en(rd_en)
    );

    task automatic check(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive, advance the bench model, check after the edge
    task automatic cyc(input string tag, input bit ce, input bit cpu, input bit ctl,
                       input bit adv, input bit [3:0] ln, input bit alln, input bit wen,
                       input int a, input logic [35:0] d);
        bit [3:0]    mask;
        bit          acc = 0;
        bit [3:0]    wr = 0;
        int          lo, ea;
        bit          exp_en;
        logic [35:0] exp_q;
        mask = !alln ? 4'hF : (!wen ? ~ln : 4'h0);
        if (!cpu || !ctl) begin
            if (ce) m_act = 0;
            else begin
                m_act = 1; m_base = a; m_k = 0; acc = 1;
                wr = cpu ? mask : 4'h0;
            end
        end else if (m_act) begin
            if (!adv) m_k = (m_k + 1) % 4;
            acc = 1; wr = mask;
        end
        lo = order_lin ? ((m_base % 4) + m_k) % 4 : ((m_base % 4) ^ m_k);
        ea = (m_base / 4) * 4 + lo;
        if (acc && wr != 0)
            for (int i = 0; i < 4; i++)
                if (wr[i]) ref_mem[ea][i*9 +: 9] = d[i*9 +: 9];
        exp_en = acc && (wr == 0);
        exp_q  = ref_mem[ea];
        ce_n = ce; strb_cpu_n = cpu; strb_ctl_n = ctl; adv_n = adv;
        lane_we_n = ln; all_we_n = alln; we_n = wen;
        addr = AW'(a); wr_data = d;
        @(posedge clk);
        @(negedge clk);
        if (exp_en)
            check(rd_en === 1'b1 && rd_data === exp_q, tag, {rd_en, rd_data}, {1'b1, exp_q});
        else
            check(rd_en === 1'b0, tag, {rd_en, rd_data}, {1'b0, rd_data});
    endtask

    function automatic logic [35:0] rnd36();
        return {$urandom(), $urandom()} & 64'hF_FFFF_FFFF;
    endfunction

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then an idle cycle with no burst
        check(rd_en === 1'b0, "R1", {rd_en, 36'h0}, 37'h0);
        cyc("R1", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);

        // fill: linear write bursts, all lanes (R7, R4)
        order_lin = 1'b1;
        for (int b = 0; b < DEPTH / 4; b++) begin
            cyc("R7", 0, 1, 0, 1, 4'hF, 0, 1, b * 4, rnd36());
            for (int k = 0; k < 3; k++)
                cyc("R4", 0, 1, 1, 0, 4'hF, 0, 1, 0, rnd36());
        end

        // sweep: both orders, every start offset, every upper address
        for (int o = 0; o < 2; o++) begin
            order_lin = o[0];
            for (int up = 0; up < DEPTH / 4; up++)
                for (int lo = 0; lo < 4; lo++) begin
                    bit [3:0] m;
                    m = 4'($urandom());
                    // R6 write burst with random lane masks
                    cyc("R6", 0, 1, 0, 1, ~m, 1, 0, up * 4 + lo, rnd36());
                    for (int k = 0; k < 3; k++) begin
                        m = 4'($urandom());
                        cyc("R6", 0, 1, 1, 0, ~m, 1, 0, 0, rnd36());
                    end
                    // R2/R9 read burst, R3 hold, R4/R5 ordering
                    cyc("R9", 0, 0, 1, 1, 4'hF, 1, 1, up * 4 + lo, '0);
                    cyc(o ? "R4" : "R5", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);
                    cyc("R3", 0, 1, 1, 1, 4'hF, 1, 1, 0, '0);
                    cyc(o ? "R4" : "R5", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);
                    cyc(o ? "R4" : "R5", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);
                end
        end

        // R7: global write overrides lane selects and we_n high
        order_lin = 1'b1;
        cyc("R7", 0, 1, 0, 1, 4'hF, 0, 1, 5, 36'h1_2345_6789);
        cyc("R7", 0, 0, 1, 1, 4'hF, 1, 1, 5, '0);
        check(rd_data === 36'h1_2345_6789, "R7", {1'b0, rd_data}, {1'b0, 36'h1_2345_6789});

        // R8: both strobes with write controls asserted -> read, memory kept
        cyc("R8", 0, 0, 0, 1, 4'h0, 0, 0, 9, 36'hF_FFFF_FFFF);
        cyc("R8", 0, 0, 1, 1, 4'hF, 1, 1, 9, '0);
        check(rd_data !== 36'hF_FFFF_FFFF || ref_mem[9] === 36'hF_FFFF_FFFF, "R8",
              {1'b0, rd_data}, {1'b0, ref_mem[9]});

        // R10: deselect, then advance with write controls -> nothing touched
        cyc("R10", 1, 1, 0, 1, 4'hF, 1, 1, 12, '0);
        cyc("R10", 0, 1, 1, 0, 4'h0, 0, 0, 0, 36'h0_0000_0000);
        cyc("R10", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);
        cyc("R10", 0, 0, 1, 1, 4'hF, 1, 1, 12, '0);
        cyc("R10", 0, 0, 1, 1, 4'hF, 1, 1, 13, '0);

        // R11: output enable acts without a clock edge
        oe_n = 1'b1; #1;
        check(rd_en === 1'b0, "R11", {rd_en, 36'h0}, 37'h0);
        oe_n = 1'b0; #1;
        check(rd_en === 1'b1 && rd_data === ref_mem[13], "R11", {rd_en, rd_data}, {1'b1, ref_mem[13]});
        oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        oe_n = 1'b0;
        cyc("R11", 0, 1, 1, 0, 4'hF, 1, 1, 0, '0);

        // R12: write beat not driven
        cyc("R12", 0, 1, 0, 1, 4'hE, 1, 0, 20, 36'h0_0000_01AB);
        cyc("R6",  0, 0, 1, 1, 4'hF, 1, 1, 20, '0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule